// File: doc/BRIEF.md
# Per-Queue Egress Leaky-Bucket Shaper

This block paces the frames leaving one switch egress port. The port has up to four priority queues. Each queue presents a frame-ready request and the length of its head frame. The shaper grants one frame at a time to the highest-priority eligible queue. It then holds the port for the frame's wire time and for an interframe gap. That gap is stretched frame by frame, so the traffic leaves evenly rather than in bursts.

Each queue's throughput is held by its own leaky bucket. A grant charges the bucket with the frame length. The bucket drains by a fixed credit on every clock, and that credit is set by a 7-bit rate code. A bucket accepts a new frame only when its level has fallen to the threshold. The gap after a frame lasts at least the minimum gap of 12 byte times. It lasts longer if the granted frame's bucket still needs time to drain back to the threshold.

With queue-based limiting enabled, only the highest active queue runs at its own programmed rate. Every lower queue runs at a binary fraction of that rate. With queue-based limiting disabled, all queues share one port-wide bucket.

Top module: `egress_shaper`

## Requirements
- R1: The reset is synchronous and active high. While it is asserted and on the first cycle after it, `tx_grant`, `gap_done`, `tx_qid` and `gap_len` are all zero, and every bucket is empty.
- R2: `qmode` picks the number of active queues: 00 gives Q0 only, 01 gives Q0 and Q1, and 10 or 11 gives all NQ queues. A queue outside the active set is never granted.
- R3: When several active queues are eligible in the same cycle, the grant goes to the one with the highest index.
- R4: Each bucket level is kept in units of 1/2^FRAC byte. A grant adds the frame length shifted left by FRAC. Every clock subtracts the bucket's credit, and the level saturates at zero. A queue is eligible only when it requests, the port is idle, and its bucket level is at or below LVL_THRESH (default 0).
- R5: The gap after a frame of L bytes, in clock cycles, is max(IFG_BYTES*BYTE_CYC, ceil(L*2^FRAC / c) + 1 - L*BYTE_CYC), where c is the credit of the charged bucket. It ends with a one-cycle `gap_done` pulse, and `gap_len` carries the gap length. The pulse comes L*BYTE_CYC + gap cycles after the grant.
- R6: No new grant is issued from a grant until the cycle after the matching `gap_done`.
- R7: A rate code of 0 on the governing field makes the bucket unlimited: its level is held at zero, and the gap is exactly IFG_BYTES*BYTE_CYC cycles.
- R8: With `qlim_en`=1, the top active queue T drains by its own code, taken from bits [7T+6:7T] of `rate_codes`. A lower queue q drains by max(1, code_T >> (T-q)), which gives the ratio 8:4:2:1. The codes in the lower queues' fields have no effect.
- R9: With `qlim_en`=0, all queues charge one shared bucket. That bucket drains by the code in `rate_codes[6:0]`.
- R10: `tx_grant` is a single-cycle pulse. `tx_qid` is valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qlim_en | input | 1 | 1: a bucket per queue; 0: one shared port bucket |
| qmode | input | 2 | Active queue count: 00 one, 01 two, 1x all |
| rate_codes | input | NQ*7 | Per-queue 7-bit rate codes, queue q at bits [7q+6:7q] |
| frame_req | input | NQ | Head-of-queue frame ready, one bit per queue |
| frame_len | input | NQ*LEN_W | Head frame length in bytes (at least 1), queue q at [q*LEN_W +: LEN_W] |
| tx_grant | output | 1 | One-cycle grant pulse |
| tx_qid | output | $clog2(NQ) | Queue granted |
| gap_done | output | 1 | One-cycle pulse at the end of the interframe gap |
| gap_len | output | LEN_W+FRAC+3 | Length of the gap just ended, in cycles |

## Verification
The bench builds the block with NQ=4, LEN_W=11, FRAC=4 and BYTE_CYC=2, so the minimum gap is 24 cycles. Frames of 1 to 96 bytes, together with codes ranging from 1 to 127, reach both limits of R5. A fast code leaves the minimum gap as the floor. A slow code makes the drain time dominate, and a single frame can then take more than a thousand cycles. Small top codes shifted down for the lower queues reach the clamp to a credit of 1. Mode 11 and the shared-bucket setting are also driven, each against the same closed-form gap and eligibility model.

// File: rtl/egsh_pkg.sv
package egsh_pkg;
  localparam int CODE_W = 7;

  typedef enum logic [1:0] {SH_IDLE, SH_TX, SH_GAP} sh_state_t;

  function automatic int unsigned queues_for_mode(logic [1:0] m, int unsigned nq);
    case (m)
      2'b00:   return 1;
      2'b01:   return 2;
      default: return nq;
    endcase
  endfunction
endpackage

// File: rtl/egsh_rate.sv
// Derives per-bucket drain credit and the unlimited flag from the codes.
module egsh_rate #(
  parameter int NQ = 4,
  parameter int CW = 7,
  parameter int QW = 2
) (
  input  logic                   qlim_en,
  input  logic [QW:0]            nact,
  input  logic [NQ*CW-1:0]       codes,
  output logic [NQ-1:0][CW-1:0]  credit,
  output logic [NQ-1:0]          unlim
);
  logic [QW-1:0] top;
  logic [CW-1:0] top_code;
  logic [CW-1:0] port_code;

  assign top       = QW'(nact - 1'b1);
  assign top_code  = codes[int'(top)*CW +: CW];
  assign port_code = codes[CW-1:0];

  for (genvar q = 0; q < NQ; q++) begin : g_q
    localparam logic [QW-1:0] QI = QW'(q);
    logic [CW-1:0] shifted;
    logic          above;
    assign shifted = top_code >> (top - QI);
    assign above   = (QI > top);
    if (q == 0) begin : g_port
      assign credit[q] = !qlim_en ? port_code
                                  : ((shifted == '0) ? CW'(1) : shifted);
      assign unlim[q]  = !qlim_en ? (port_code == '0) : (top_code == '0);
    end else begin : g_rest
      assign credit[q] = (!qlim_en || above) ? '0
                                             : ((shifted == '0) ? CW'(1) : shifted);
      assign unlim[q]  = (!qlim_en || above) ? 1'b1 : (top_code == '0);
    end
  end
endmodule

// File: rtl/egsh_bucket.sv
// One leaky bucket: charged on grant, drained every clock by its credit.
module egsh_bucket #(
  parameter int LEN_W      = 11,
  parameter int FRAC       = 4,
  parameter int CW         = 7,
  parameter int LVL_THRESH = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    credit,
  input  logic             unlim,
  input  logic             charge,
  input  logic [LEN_W-1:0] len,
  output logic             ok
);
  localparam int LVL_W = LEN_W + FRAC + 2;

  logic [LVL_W-1:0] level;
  logic [LVL_W-1:0] drained;
  logic [LVL_W-1:0] add;

  assign drained = (level > LVL_W'(credit)) ? level - LVL_W'(credit) : '0;
  assign add     = charge ? (LVL_W'(len) << FRAC) : '0;

  always_ff @(posedge clk) begin
    if (rst || unlim) level <= '0;
    else              level <= drained + add;
  end

  assign ok = unlim || (level <= LVL_W'(LVL_THRESH));
endmodule

// File: rtl/egsh_pick.sv
// Fixed-priority pick: highest index wins.
module egsh_pick #(
  parameter int NQ = 4,
  parameter int QW = 2
) (
  input  logic [NQ-1:0] elig,
  output logic          any,
  output logic [QW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < NQ; i++) begin
      if (elig[i]) idx = QW'(i);
    end
  end
  assign any = |elig;
endmodule

// File: rtl/egress_shaper.sv
module egress_shaper
  import egsh_pkg::*;
#(
  parameter int NQ         = 4,
  parameter int LEN_W      = 11,
  parameter int FRAC       = 4,
  parameter int BYTE_CYC   = 1,
  parameter int IFG_BYTES  = 12,
  parameter int LVL_THRESH = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      qlim_en,
  input  logic [1:0]                qmode,
  input  logic [NQ*CODE_W-1:0]      rate_codes,
  input  logic [NQ-1:0]             frame_req,
  input  logic [NQ*LEN_W-1:0]       frame_len,
  output logic                      tx_grant,
  output logic [$clog2(NQ)-1:0]     tx_qid,
  output logic                      gap_done,
  output logic [LEN_W+FRAC+2:0]     gap_len
);
  localparam int CW      = CODE_W;
  localparam int QW      = $clog2(NQ);
  localparam int GAP_W   = LEN_W + FRAC + 3;
  localparam int IFG_CYC = IFG_BYTES * BYTE_CYC;
  localparam int TX_W    = LEN_W + $clog2(BYTE_CYC + 1) + 1;

  logic [QW:0]                nact;
  logic [NQ-1:0][CW-1:0]      credit;
  logic [NQ-1:0]              unlim, b_ok, elig, charge;
  logic [NQ-1:0][LEN_W-1:0]   lens;
  logic                       grant_now;
  logic [QW-1:0]              pick, bsel, lastb;
  logic [LEN_W-1:0]           sel_len;
  logic [TX_W-1:0]            frame_cyc, tx_cnt;
  logic [GAP_W-1:0]           gcnt, gnext;
  sh_state_t                  state;

  assign nact = (QW+1)'(queues_for_mode(qmode, NQ));

  egsh_rate #(.NQ(NQ), .CW(CW), .QW(QW)) u_rate (
    .qlim_en (qlim_en),
    .nact    (nact),
    .codes   (rate_codes),
    .credit  (credit),
    .unlim   (unlim)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign lens[q]   = frame_len[q*LEN_W +: LEN_W];
    assign elig[q]   = (state == SH_IDLE) && frame_req[q] &&
                       ((QW+1)'(q) < nact) &&
                       (qlim_en ? b_ok[q] : b_ok[0]);
    assign charge[q] = grant_now && (bsel == QW'(q));

    egsh_bucket #(
      .LEN_W(LEN_W), .FRAC(FRAC), .CW(CW), .LVL_THRESH(LVL_THRESH)
    ) u_bkt (
      .clk    (clk),
      .rst    (rst),
      .credit (credit[q]),
      .unlim  (unlim[q]),
      .charge (charge[q]),
      .len    (sel_len),
      .ok     (b_ok[q])
    );
  end

  egsh_pick #(.NQ(NQ), .QW(QW)) u_pick (
    .elig (elig),
    .any  (grant_now),
    .idx  (pick)
  );

  assign bsel      = qlim_en ? pick : '0;
  assign sel_len   = lens[pick];
  assign frame_cyc = TX_W'(sel_len) * TX_W'(BYTE_CYC);
  assign gnext     = gcnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SH_IDLE;
      tx_grant <= 1'b0;
      tx_qid   <= '0;
      gap_done <= 1'b0;
      gap_len  <= '0;
      tx_cnt   <= '0;
      gcnt     <= '0;
      lastb    <= '0;
    end else begin
      tx_grant <= 1'b0;
      gap_done <= 1'b0;
      case (state)
        SH_IDLE: begin
          if (grant_now) begin
            tx_grant <= 1'b1;
            tx_qid   <= pick;
            lastb    <= bsel;
            tx_cnt   <= frame_cyc - 1'b1;
            state    <= SH_TX;
          end
        end
        SH_TX: begin
          if (tx_cnt == '0) begin
            gcnt  <= '0;
            state <= SH_GAP;
          end else begin
            tx_cnt <= tx_cnt - 1'b1;
          end
        end
        SH_GAP: begin
          gcnt <= gnext;
          if ((gnext >= GAP_W'(IFG_CYC)) && b_ok[lastb]) begin
            gap_done <= 1'b1;
            gap_len  <= gnext;
            state    <= SH_IDLE;
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/egress_shaper_chk.sv
module egress_shaper_chk
  import egsh_pkg::*;
#(
  parameter int NQ        = 4,
  parameter int LEN_W     = 11,
  parameter int FRAC      = 4,
  parameter int BYTE_CYC  = 1,
  parameter int IFG_BYTES = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic [1:0]            qmode,
  input logic [NQ-1:0]         frame_req,
  input logic                  tx_grant,
  input logic [$clog2(NQ)-1:0] tx_qid,
  input logic                  gap_done,
  input logic [LEN_W+FRAC+2:0] gap_len
);
  localparam int IFG_CYC = IFG_BYTES * BYTE_CYC;

  logic [NQ-1:0] req_q;
  logic [1:0]    mode_q;
  logic          busy;

  always_ff @(posedge clk) begin
    req_q  <= frame_req;
    mode_q <= qmode;
    if (rst)           busy <= 1'b0;
    else if (tx_grant) busy <= 1'b1;
    else if (gap_done) busy <= 1'b0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!tx_grant && !gap_done));

  // R10
  grant_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_grant |=> !tx_grant);

  // R2
  qid_range_chk: assert property (@(posedge clk) disable iff (rst)
    tx_grant |-> (int'(tx_qid) < int'(queues_for_mode(mode_q, NQ))));

  // R3
  grant_req_chk: assert property (@(posedge clk) disable iff (rst)
    tx_grant |-> req_q[tx_qid]);

  // R5
  min_gap_chk: assert property (@(posedge clk) disable iff (rst)
    gap_done |-> (int'(gap_len) >= IFG_CYC));

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    tx_grant |-> !busy);

  // R6
  gap_follows_grant_chk: assert property (@(posedge clk) disable iff (rst)
    gap_done |-> busy);
endmodule

bind egress_shaper egress_shaper_chk #(
  .NQ(NQ), .LEN_W(LEN_W), .FRAC(FRAC), .BYTE_CYC(BYTE_CYC), .IFG_BYTES(IFG_BYTES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .qmode     (qmode),
  .frame_req (frame_req),
  .tx_grant  (tx_grant),
  .tx_qid    (tx_qid),
  .gap_done  (gap_done),
  .gap_len   (gap_len)
);

// File: tb/tb_egress_shaper.sv
`timescale 1ns/1ps
module tb_egress_shaper;
  localparam int NQ        = 4;
  localparam int LEN_W     = 11;
  localparam int FRAC      = 4;
  localparam int BYTE_CYC  = 2;
  localparam int IFG_BYTES = 12;
  localparam int IFG       = IFG_BYTES * BYTE_CYC;
  localparam int QW        = 2;
  localparam int GAP_W     = LEN_W + FRAC + 3;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 qlim_en = 1'b1;
  logic [1:0]           qmode = 2'b00;
  logic [NQ*7-1:0]      rate_codes = '0;
  logic [NQ-1:0]        frame_req = '0;
  logic [NQ*LEN_W-1:0]  frame_len = '0;
  logic                 tx_grant;
  logic [QW-1:0]        tx_qid;
  logic                 gap_done;
  logic [GAP_W-1:0]     gap_len;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    busy = 0;
  bit    prev_grant = 0;
  int    g_end = 0;
  int    exp_gap = 0;
  string gap_tag = "R5";
  int    ready [NQ];

  always #2 clk = ~clk;

  egress_shaper #(
    .NQ(NQ), .LEN_W(LEN_W), .FRAC(FRAC), .BYTE_CYC(BYTE_CYC), .IFG_BYTES(IFG_BYTES)
  ) dut (
    .clk(clk), .rst(rst), .qlim_en(qlim_en), .qmode(qmode),
    .rate_codes(rate_codes), .frame_req(frame_req), .frame_len(frame_len),
    .tx_grant(tx_grant), .tx_qid(tx_qid), .gap_done(gap_done), .gap_len(gap_len)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int nact_f();
    return (qmode == 2'b00) ? 1 : (qmode == 2'b01) ? 2 : NQ;
  endfunction

  function automatic int code_f(int i);
    return int'(rate_codes[i*7 +: 7]);
  endfunction

  // R8 / R9: governing code and credit of the bucket queue q charges
  function automatic void rate_f(int q, output int c, output bit unl);
    int top, tc;
    if (!qlim_en) begin
      tc = code_f(0); c = tc; unl = (tc == 0);
    end else begin
      top = nact_f() - 1; tc = code_f(top); unl = (tc == 0);
      c = tc >> (top - q);
      if (c == 0) c = 1;
    end
  endfunction

  task automatic model_step();
    int c, b, L, LB, k, q_exp;
    bit unl, g_exp;
    if (rst) return;
    if (tx_grant && prev_grant) chk(0, "R10", 1, 0);
    if (busy) begin
      if (tx_grant) chk(0, "R6", 1, 0);
      if (gap_done || cyc == g_end) begin
        chk(gap_done == (cyc == g_end), gap_tag, int'(gap_done), int'(cyc == g_end));
        if (gap_done && cyc == g_end) chk(int'(gap_len) == exp_gap, gap_tag, int'(gap_len), exp_gap);
      end
      if (cyc == g_end) busy = 0;
    end else begin
      g_exp = 0; q_exp = 0;
      for (int q = 0; q < NQ; q++) begin
        rate_f(q, c, unl);
        b = qlim_en ? q : 0;
        if (q < nact_f() && frame_req[q] && (unl || cyc >= ready[b])) begin
          g_exp = 1; q_exp = q;
        end
      end
      if (gap_done) chk(0, "R5", 1, 0);
      if (g_exp || tx_grant) begin
        chk(tx_grant == g_exp, "R4", int'(tx_grant), int'(g_exp));
        if (tx_grant) chk(int'(tx_qid) < nact_f(), "R2", int'(tx_qid), nact_f() - 1);
        if (tx_grant && g_exp) chk(int'(tx_qid) == q_exp, "R3", int'(tx_qid), q_exp);
      end
      if (g_exp) begin
        rate_f(q_exp, c, unl);
        b  = qlim_en ? q_exp : 0;
        L  = int'(frame_len[q_exp*LEN_W +: LEN_W]);
        LB = L * BYTE_CYC;
        if (unl) begin
          exp_gap = IFG; ready[b] = cyc; gap_tag = "R7";
        end else begin
          k = ((L << FRAC) + c - 1) / c;
          exp_gap = (k + 1 - LB > IFG) ? (k + 1 - LB) : IFG;
          ready[b] = cyc + k + 1;
          gap_tag = !qlim_en ? "R9" : (q_exp < nact_f() - 1) ? "R8" : "R5";
        end
        g_end = cyc + LB + exp_gap;
        busy = 1;
      end
    end
    prev_grant = tx_grant;
  endtask

  task automatic drive_rand();
    for (int q = 0; q < NQ; q++) begin
      frame_req[q] = (($urandom % 10) < 7);
      frame_len[q*LEN_W +: LEN_W] = LEN_W'(1 + ($urandom % 96));
    end
  endtask

  task automatic phase(input bit ql, input logic [1:0] m, input logic [NQ*7-1:0] codes, input int n);
    qlim_en = ql; qmode = m; rate_codes = codes; rst = 1'b1;
    drive_rand();
    repeat (3) begin @(posedge clk); #1; cyc++; end
    // R1: outputs idle under reset
    chk(!tx_grant && !gap_done && gap_len == '0 && tx_qid == '0, "R1",
        int'(tx_grant) + int'(gap_done) + int'(gap_len) + int'(tx_qid), 0);
    rst = 1'b0; busy = 0; prev_grant = 0;
    for (int q = 0; q < NQ; q++) ready[q] = 0;
    repeat (n) begin
      @(posedge clk); #1; cyc++;
      model_step();
      drive_rand();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    for (int q = 0; q < NQ; q++) ready[q] = 0;
    // R7: unlimited single queue, gap equals the minimum
    phase(1'b1, 2'b00, {7'd5, 7'd9, 7'd11, 7'd0}, 2000);
    // R8: top code 8, junk in lower fields, four queues
    phase(1'b1, 2'b10, {7'd8, 7'd99, 7'd3, 7'd77}, 5000);
    // R2: two-queue mode, top is Q1
    phase(1'b1, 2'b01, {7'd1, 7'd2, 7'd20, 7'd6}, 4000);
    // R9: shared port bucket
    phase(1'b0, 2'b10, {7'd50, 7'd40, 7'd30, 7'd6}, 5000);
    // R5: fastest code, minimum gap floor
    phase(1'b1, 2'b11, {7'd127, 7'd1, 7'd1, 7'd1}, 3000);
    // R8: small top code, lower credits clamp to 1
    phase(1'b1, 2'b11, {7'd3, 7'd0, 7'd0, 7'd0}, 6000);
    for (int p = 0; p < 8; p++) begin
      logic [NQ*7-1:0] cds;
      for (int q = 0; q < NQ; q++) cds[q*7 +: 7] = (($urandom % 8) == 0) ? 7'd0 : 7'(1 + ($urandom % 127));
      phase(1'(($urandom % 4) != 0), 2'($urandom % 4), cds, 5000);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule